// File: doc/BRIEF.md
# Mailbox Command Requester

This block lets a local client hand one command at a time to a power-management microcontroller. The client and the microcontroller share three word-wide mailbox registers: a message-identifier register, an argument register and a response register. The client presents an identifier and a 32-bit argument with a valid/ready handshake. The block first waits for the mailbox to leave the busy state. It then zeroes the response register, loads the argument, and writes the identifier, which starts the transaction on the far side. It then polls the response register until the value is nonzero or a retry budget is spent.

A done pulse returns a status, the raw response byte and, when the microcontroller replied, the argument register read back afterwards. A response of 0xFF is acknowledged by writing 0x01 back into the response register before the client is told. The register port is a single-outstanding read/write bus. A request is held on that bus until ready is seen. The time between polls is a cycle count derived from the clock rate and a microsecond setting. The retry budget is a parameter.

Top module: `mbox_requester`

## Requirements
- R1: After reset, req_ready is 1, done is 0 and bus_req is 0.
- R2: A request whose identifier is 0x00 or 0x18 or above produces a done pulse in the cycle after acceptance, with status 5 (bad identifier), code 0 and data 0, and no bus access at all.
- R3: Before any write, the response register is read until its whole word is nonzero, with at least POLL_GAP cycles between consecutive reads. No write occurs while it still reads zero.
- R4: If the response register reads zero on RETRY_MAX+1 reads before the issue, the command ends with status 3 (pre-issue timeout), code 0, data 0 and no writes.
- R5: A valid command issues exactly these writes in this order: 0 to the response register, the argument to the argument register, then the identifier (zero-extended) to the message register. Bus request fields stay stable until ready.
- R6: After the identifier write, the response register is polled again. The first nonzero read ends the poll, and its low byte is reported as the code.
- R7: Code 0x01 gives status 0 (OK), and data equals the argument register read after the reply.
- R8: Code 0xFF gives status 1 (failed) and data 0, and 0x01 is written to the response register as a fourth and last write.
- R9: Any other nonzero code (for example 0xFE unknown, 0xFD missing prerequisite, 0xFC busy) gives status 2 (rejected), the raw code, and data equal to the argument register read back.
- R10: If the response register reads zero on RETRY_MAX+1 reads after the issue, the command ends with status 4 (post-issue timeout), code 0 and data 0, with no write after the identifier.
- R11: req_ready falls the cycle after a valid request is accepted and stays low until done. A request held valid meanwhile is ignored and starts no bus traffic.
- R12: done is high for exactly one cycle per accepted request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Client presents a command |
| req_ready | output | 1 | Block is idle and accepts a command |
| req_id | input | 8 | Message identifier |
| req_arg | input | 32 | Command argument |
| done | output | 1 | One-cycle completion pulse |
| done_status | output | 3 | 0 OK, 1 failed, 2 rejected, 3 pre timeout, 4 post timeout, 5 bad identifier |
| done_code | output | 8 | Low byte of the final response, 0 when none |
| done_data | output | 32 | Argument register read back after reply |
| bus_req | output | 1 | Register access requested |
| bus_we | output | 1 | 1 write, 0 read |
| bus_addr | output | ADDR_W | Register address |
| bus_wdata | output | 32 | Write data |
| bus_rdata | input | 32 | Read data, valid with bus_ready |
| bus_ready | input | 1 | Access completes this cycle |

## Verification
The bad-identifier result is due one cycle after acceptance. The bench samples it on the first falling edge after the accepting edge. Every other result arrives an unknown number of cycles later, because bus latency and the microcontroller model's reply delay vary. For these, the bench samples done on each falling edge, takes status, code and data from the edge where done is high, and checks one falling edge later that done has gone low. Between acceptance and done, req_ready is checked on every falling edge, and the bus model logs each access so that write order and poll counts can be compared once the command has finished.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

    localparam int unsigned MBOX_DATA_W = 32;
    localparam int unsigned MBOX_ID_W   = 8;
    localparam logic [7:0]  ID_LIMIT    = 8'h18;

    localparam logic [7:0] RSP_BUSY   = 8'h00;
    localparam logic [7:0] RSP_OK     = 8'h01;
    localparam logic [7:0] RSP_FAILED = 8'hFF;

    typedef enum logic [2:0] {
        ST_OK           = 3'd0,
        ST_FAIL         = 3'd1,
        ST_REJECT       = 3'd2,
        ST_PRE_TIMEOUT  = 3'd3,
        ST_POST_TIMEOUT = 3'd4,
        ST_BAD_ID       = 3'd5
    } mbox_status_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_PRE_RD,
        S_PRE_GAP,
        S_CLR,
        S_ARG,
        S_TRIG,
        S_POST_RD,
        S_POST_GAP,
        S_ACK_FAIL,
        S_READBACK
    } mbox_state_e;

    typedef struct packed {
        mbox_status_e              status;
        logic [7:0]                code;
        logic [MBOX_DATA_W-1:0]    data;
    } mbox_result_t;

    function automatic logic id_is_valid(input logic [MBOX_ID_W-1:0] id);
        return (id != '0) && (id < ID_LIMIT);
    endfunction

    function automatic mbox_status_e classify(input logic [7:0] code);
        if (code == RSP_OK)          return ST_OK;
        else if (code == RSP_FAILED) return ST_FAIL;
        else                         return ST_REJECT;
    endfunction

endpackage

// File: rtl/mbox_poll_timer.sv
module mbox_poll_timer #(
    parameter int unsigned GAP     = 1000,
    parameter int unsigned RETRIES = 200000
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic wait_start,
    output logic gap_done,
    output logic last_try
);
    localparam int unsigned GAP_W = (GAP > 1) ? $clog2(GAP + 1) : 1;
    localparam int unsigned TRY_W = (RETRIES > 1) ? $clog2(RETRIES + 1) : 1;

    logic [GAP_W-1:0] gap_cnt;
    logic [TRY_W-1:0] tries;
    logic             running;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap_cnt  <= '0;
            tries    <= '0;
            running  <= 1'b0;
            gap_done <= 1'b0;
        end else begin
            gap_done <= 1'b0;
            if (clear) begin
                tries   <= '0;
                running <= 1'b0;
            end else if (wait_start) begin
                tries   <= tries + 1'b1;
                running <= 1'b1;
                gap_cnt <= GAP_W'(GAP - 1);
            end else if (running) begin
                if (gap_cnt == '0) begin
                    running  <= 1'b0;
                    gap_done <= 1'b1;
                end else begin
                    gap_cnt <= gap_cnt - 1'b1;
                end
            end
        end
    end

    assign last_try = (tries == TRY_W'(RETRIES));

    // R4
    retry_bound_chk: assert property (@(posedge clk) disable iff (rst)
        wait_start |-> !last_try);

    // R3
    gap_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        wait_start |=> !gap_done);

endmodule

// File: rtl/mbox_bus_master.sv
module mbox_bus_master #(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  logic              go_we,
    input  logic [ADDR_W-1:0] go_addr,
    input  logic [DATA_W-1:0] go_wdata,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              bus_ready,
    output logic              ack,
    output logic [DATA_W-1:0] ack_rdata
);
    always_ff @(posedge clk) begin
        if (rst) begin
            bus_req   <= 1'b0;
            bus_we    <= 1'b0;
            bus_addr  <= '0;
            bus_wdata <= '0;
            ack       <= 1'b0;
            ack_rdata <= '0;
        end else begin
            ack <= 1'b0;
            if (bus_req && bus_ready) begin
                bus_req   <= 1'b0;
                ack       <= 1'b1;
                ack_rdata <= bus_rdata;
            end else if (go && !bus_req) begin
                bus_req   <= 1'b1;
                bus_we    <= go_we;
                bus_addr  <= go_addr;
                bus_wdata <= go_wdata;
            end
        end
    end

    // R5
    hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_ready) |=> (bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata)));

    // R5
    go_when_free_chk: assert property (@(posedge clk) disable iff (rst)
        go |-> !bus_req);

endmodule

// File: rtl/mbox_requester.sv
module mbox_requester
    import mbox_pkg::*;
#(
    parameter int unsigned ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] MSG_ADDR = 16'h0000,
    parameter logic [ADDR_W-1:0] ARG_ADDR = 16'h0004,
    parameter logic [ADDR_W-1:0] RSP_ADDR = 16'h0008,
    parameter int unsigned CLK_MHZ   = 100,
    parameter int unsigned POLL_US   = 10,
    parameter int unsigned POLL_GAP  = CLK_MHZ * POLL_US,
    parameter int unsigned RETRY_MAX = 200000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [7:0]        req_id,
    input  logic [31:0]       req_arg,
    output logic              done,
    output logic [2:0]        done_status,
    output logic [7:0]        done_code,
    output logic [31:0]       done_data,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [31:0]       bus_wdata,
    input  logic [31:0]       bus_rdata,
    input  logic              bus_ready
);
    localparam int unsigned DW = MBOX_DATA_W;

    mbox_state_e    state, state_d;
    logic [7:0]     id_q;
    logic [DW-1:0]  arg_q;
    logic [7:0]     code_q, code_d;
    mbox_result_t   res_q, fin_res;
    logic           done_q, fin, take;

    logic           go, go_we;
    logic [ADDR_W-1:0] go_addr;
    logic [DW-1:0]  go_wdata;
    logic           ack;
    logic [DW-1:0]  ack_rdata;
    logic           t_clear, t_wait, gap_done, last_try;

    mbox_bus_master #(.ADDR_W(ADDR_W), .DATA_W(DW)) u_bus (
        .clk(clk), .rst(rst),
        .go(go), .go_we(go_we), .go_addr(go_addr), .go_wdata(go_wdata),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ready(bus_ready),
        .ack(ack), .ack_rdata(ack_rdata)
    );

    mbox_poll_timer #(.GAP(POLL_GAP), .RETRIES(RETRY_MAX)) u_timer (
        .clk(clk), .rst(rst),
        .clear(t_clear), .wait_start(t_wait),
        .gap_done(gap_done), .last_try(last_try)
    );

    always_comb begin
        state_d  = state;
        code_d   = code_q;
        go       = 1'b0;
        go_we    = 1'b0;
        go_addr  = RSP_ADDR;
        go_wdata = '0;
        t_clear  = 1'b0;
        t_wait   = 1'b0;
        take     = 1'b0;
        fin      = 1'b0;
        fin_res  = '{status: ST_OK, code: 8'h00, data: '0};
        unique case (state)
            S_IDLE: begin
                if (req_valid) begin
                    take = 1'b1;
                    if (!id_is_valid(req_id)) begin
                        fin            = 1'b1;
                        fin_res.status = ST_BAD_ID;
                    end else begin
                        t_clear = 1'b1;
                        go      = 1'b1;
                        state_d = S_PRE_RD;
                    end
                end
            end
            S_PRE_RD: begin
                if (ack) begin
                    if (ack_rdata != '0) begin
                        go       = 1'b1;
                        go_we    = 1'b1;
                        go_addr  = RSP_ADDR;
                        go_wdata = '0;
                        state_d  = S_CLR;
                    end else if (last_try) begin
                        fin            = 1'b1;
                        fin_res.status = ST_PRE_TIMEOUT;
                        state_d        = S_IDLE;
                    end else begin
                        t_wait  = 1'b1;
                        state_d = S_PRE_GAP;
                    end
                end
            end
            S_PRE_GAP: begin
                if (gap_done) begin
                    go      = 1'b1;
                    state_d = S_PRE_RD;
                end
            end
            S_CLR: begin
                if (ack) begin
                    go       = 1'b1;
                    go_we    = 1'b1;
                    go_addr  = ARG_ADDR;
                    go_wdata = arg_q;
                    state_d  = S_ARG;
                end
            end
            S_ARG: begin
                if (ack) begin
                    go       = 1'b1;
                    go_we    = 1'b1;
                    go_addr  = MSG_ADDR;
                    go_wdata = {{(DW-8){1'b0}}, id_q};
                    state_d  = S_TRIG;
                end
            end
            S_TRIG: begin
                if (ack) begin
                    t_clear = 1'b1;
                    go      = 1'b1;
                    state_d = S_POST_RD;
                end
            end
            S_POST_RD: begin
                if (ack) begin
                    if (ack_rdata != '0) begin
                        code_d = ack_rdata[7:0];
                        go     = 1'b1;
                        if (classify(ack_rdata[7:0]) == ST_FAIL) begin
                            go_we    = 1'b1;
                            go_addr  = RSP_ADDR;
                            go_wdata = {{(DW-8){1'b0}}, RSP_OK};
                            state_d  = S_ACK_FAIL;
                        end else begin
                            go_addr  = ARG_ADDR;
                            state_d  = S_READBACK;
                        end
                    end else if (last_try) begin
                        fin            = 1'b1;
                        fin_res.status = ST_POST_TIMEOUT;
                        state_d        = S_IDLE;
                    end else begin
                        t_wait  = 1'b1;
                        state_d = S_POST_GAP;
                    end
                end
            end
            S_POST_GAP: begin
                if (gap_done) begin
                    go      = 1'b1;
                    state_d = S_POST_RD;
                end
            end
            S_ACK_FAIL: begin
                if (ack) begin
                    fin            = 1'b1;
                    fin_res.status = ST_FAIL;
                    fin_res.code   = RSP_FAILED;
                    state_d        = S_IDLE;
                end
            end
            S_READBACK: begin
                if (ack) begin
                    fin            = 1'b1;
                    fin_res.status = classify(code_q);
                    fin_res.code   = code_q;
                    fin_res.data   = ack_rdata;
                    state_d        = S_IDLE;
                end
            end
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= S_IDLE;
            id_q   <= '0;
            arg_q  <= '0;
            code_q <= '0;
            done_q <= 1'b0;
            res_q  <= '{status: ST_OK, code: 8'h00, data: '0};
        end else begin
            state  <= state_d;
            code_q <= code_d;
            done_q <= fin;
            if (fin) res_q <= fin_res;
            if (take) begin
                id_q  <= req_id;
                arg_q <= req_arg;
            end
        end
    end

    assign req_ready   = (state == S_IDLE);
    assign done        = done_q;
    assign done_status = res_q.status;
    assign done_code   = res_q.code;
    assign done_data   = res_q.data;

    // R11
    busy_refuse_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && id_is_valid(req_id)) |=> !req_ready);

    // R12
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R2
    bad_id_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && !id_is_valid(req_id)) |=>
            (done && done_status == ST_BAD_ID && !bus_req));

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (req_ready && !$past(req_ready)) |-> !bus_req);

endmodule

// File: tb/tb_mbox_requester.sv
module tb_mbox_requester;
    localparam int CLK_PERIOD = 10;
    localparam int GAP        = 4;
    localparam int RETRIES    = 5;
    localparam logic [15:0] A_MSG = 16'h0000;
    localparam logic [15:0] A_ARG = 16'h0004;
    localparam logic [15:0] A_RSP = 16'h0008;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [7:0]  req_id = '0;
    logic [31:0] req_arg = '0;
    logic        done;
    logic [2:0]  done_status;
    logic [7:0]  done_code;
    logic [31:0] done_data;
    logic        bus_req, bus_we;
    logic [15:0] bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata = '0;
    logic        bus_ready = 1'b0;

    int n_cmp = 0;
    int n_bad = 0;

    mbox_requester #(
        .ADDR_W(16), .MSG_ADDR(A_MSG), .ARG_ADDR(A_ARG), .RSP_ADDR(A_RSP),
        .POLL_GAP(GAP), .RETRY_MAX(RETRIES)
    ) dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_id(req_id), .req_arg(req_arg),
        .done(done), .done_status(done_status), .done_code(done_code), .done_data(done_data),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_ready(bus_ready)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // mailbox model state
    logic [31:0] mb_msg = '0, mb_arg = '0, mb_rsp = 32'h1;
    int  fw_delay = 0, fw_cnt = 0, pre_cnt = 0;
    logic [7:0]  fw_code = '0;
    logic [31:0] fw_result = '0;
    bit  pre_pending = 0, wr_while_busy = 0;
    int  lat_left = 0;
    int  acc_n = 0, wr_n = 0, rd_pre = 0, rd_post = 0;
    logic [15:0] wr_addr [8];
    logic [31:0] wr_data [8];

    initial begin
        forever begin
            @(negedge clk);
            if (bus_ready) begin
                bus_ready = 1'b0;
            end else if (bus_req) begin
                if (lat_left == 0) begin
                    acc_n++;
                    bus_ready = 1'b1;
                    if (bus_we) begin
                        if (pre_pending) wr_while_busy = 1;
                        if (wr_n < 8) begin
                            wr_addr[wr_n] = bus_addr;
                            wr_data[wr_n] = bus_wdata;
                        end
                        wr_n++;
                        case (bus_addr)
                            A_MSG: begin mb_msg = bus_wdata; fw_cnt = fw_delay; end
                            A_ARG: mb_arg = bus_wdata;
                            A_RSP: mb_rsp = bus_wdata;
                            default: ;
                        endcase
                    end else begin
                        case (bus_addr)
                            A_MSG: bus_rdata = mb_msg;
                            A_ARG: bus_rdata = mb_arg;
                            A_RSP: begin
                                bus_rdata = mb_rsp;
                                if (wr_n == 0) rd_pre++;
                                else if (wr_n >= 3) rd_post++;
                            end
                            default: bus_rdata = 32'hDEAD_BEEF;
                        endcase
                    end
                    lat_left = $urandom % 3;
                end else begin
                    lat_left--;
                end
            end
            if (fw_cnt > 0) begin
                fw_cnt--;
                if (fw_cnt == 0) begin
                    mb_rsp = {24'h0, fw_code};
                    mb_arg = fw_result;
                end
            end
            if (pre_cnt > 0) begin
                pre_cnt--;
                if (pre_cnt == 0) begin
                    mb_rsp = 32'h1;
                    pre_pending = 0;
                end
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    function automatic int exp_status(input logic [7:0] code);
        if (code == 8'h01) return 0;
        if (code == 8'hFF) return 1;
        return 2;
    endfunction

    // pre: 0 mailbox idle, >0 idle after pre cycles, <0 never idle
    // fwd: reply delay in cycles after the identifier write, 0 = no reply
    task automatic run_cmd(input logic [7:0] id, input logic [31:0] arg, input int pre,
                           input int fwd, input logic [7:0] code, input logic [31:0] result,
                           input bit hold);
        bit bad;
        int e_st, e_wr, waited, acc_at_done;
        logic [7:0]  e_code;
        logic [31:0] e_data;
        logic [2:0]  g_st;
        logic [7:0]  g_code;
        logic [31:0] g_data;
        bit ready_ok;
        bad = (id == 8'h00) || (id >= 8'h18);
        @(posedge clk);
        #1;
        wr_n = 0; rd_pre = 0; rd_post = 0; wr_while_busy = 0;
        fw_delay = fwd; fw_code = code; fw_result = result; fw_cnt = 0;
        if (pre == 0) begin mb_rsp = 32'h1; pre_pending = 0; pre_cnt = 0; end
        else if (pre > 0) begin mb_rsp = 32'h0; pre_pending = 1; pre_cnt = pre; end
        else begin mb_rsp = 32'h0; pre_pending = 1; pre_cnt = 0; end
        @(negedge clk);
        req_valid = 1'b1; req_id = id; req_arg = arg;
        waited = 0; ready_ok = 1;
        do begin
            @(negedge clk);
            waited++;
            if (waited == 1) begin
                if (hold) req_id = 8'h07;
                else req_valid = 1'b0;
            end
            if (!done && req_ready) ready_ok = 0;
        end while (!done && waited < 3000);
        req_valid = 1'b0;
        g_st = done_status; g_code = done_code; g_data = done_data;
        acc_at_done = acc_n;
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL R12: actual no done expected done for id 0x%0h", id);
        end
        if (!bad) chk("R11 ready low while busy", 32'(ready_ok), 32'd1);
        else chk("R2 done one cycle after accept", 32'(waited), 32'd1);
        @(negedge clk);
        chk("R12 done single cycle", 32'(done), 32'd0);
        e_code = '0; e_data = '0; e_wr = 0;
        if (bad) e_st = 5;
        else if (pre < 0) e_st = 3;
        else if (fwd == 0) begin e_st = 4; e_wr = 3; end
        else begin
            e_code = code; e_st = exp_status(code);
            e_data = (code == 8'hFF) ? 32'h0 : result;
            e_wr = (code == 8'hFF) ? 4 : 3;
        end
        case (e_st)
            0: chk("R7 status", 32'(g_st), 32'(e_st));
            1: chk("R8 status", 32'(g_st), 32'(e_st));
            2: chk("R9 status", 32'(g_st), 32'(e_st));
            3: chk("R4 status", 32'(g_st), 32'(e_st));
            4: chk("R10 status", 32'(g_st), 32'(e_st));
            default: chk("R2 status", 32'(g_st), 32'(e_st));
        endcase
        chk("R6 code", 32'(g_code), 32'(e_code));
        chk("R7 R8 R9 data", g_data, e_data);
        chk("R5 write count", 32'(wr_n), 32'(e_wr));
        if (bad) chk("R2 no bus access", 32'(rd_pre), 32'd0);
        if (pre < 0) chk("R4 pre reads", 32'(rd_pre), 32'(RETRIES + 1));
        if (pre > 0) chk("R3 no write while busy", 32'(wr_while_busy), 32'd0);
        if (!bad && pre >= 0 && wr_n >= 3) begin
            chk("R5 first write addr", 32'(wr_addr[0]), 32'(A_RSP));
            chk("R5 first write data", wr_data[0], 32'h0);
            chk("R5 second write addr", 32'(wr_addr[1]), 32'(A_ARG));
            chk("R5 second write data", wr_data[1], arg);
            chk("R5 third write addr", 32'(wr_addr[2]), 32'(A_MSG));
            chk("R5 third write data", wr_data[2], {24'h0, id});
        end
        if (e_st == 1 && wr_n >= 4) begin
            chk("R8 fail ack addr", 32'(wr_addr[3]), 32'(A_RSP));
            chk("R8 fail ack data", wr_data[3], 32'h1);
        end
        if (e_st == 4) chk("R10 post reads", 32'(rd_post), 32'(RETRIES + 1));
        if (hold) begin
            repeat (10) @(negedge clk);
            chk("R11 held request ignored", 32'(acc_n - acc_at_done), 32'd0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h1234_5678));
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 req_ready", 32'(req_ready), 32'd1);
        chk("R1 done", 32'(done), 32'd0);
        chk("R1 bus_req", 32'(bus_req), 32'd0);

        run_cmd(8'h04, 32'd600,      0, 5, 8'h01, 32'd612, 0);  // R7
        run_cmd(8'h15, 32'h0001_0008, 0, 3, 8'hFF, 32'hAAAA, 0); // R8
        run_cmd(8'h09, 32'h55,       0, 7, 8'hFE, 32'h77, 0);   // R9
        run_cmd(8'h11, 32'h1,        0, 2, 8'hFD, 32'h88, 0);   // R9
        run_cmd(8'h17, 32'h0,        0, 9, 8'hFC, 32'h99, 0);   // R9
        run_cmd(8'h18, 32'h12,       0, 3, 8'h01, 32'h0, 0);    // R2
        run_cmd(8'h00, 32'h12,       0, 3, 8'h01, 32'h0, 0);    // R2
        run_cmd(8'h01, 32'h0,        12, 4, 8'h01, 32'h42, 0);  // R3
        run_cmd(8'h02, 32'h0,        -1, 4, 8'h01, 32'h42, 0);  // R4
        run_cmd(8'h06, 32'h321,      0, 0, 8'h01, 32'h42, 0);   // R10
        run_cmd(8'h03, 32'h9,        0, 6, 8'h01, 32'hBEEF, 1); // R11

        for (int k = 0; k < 40; k++) begin
            logic [7:0] rid, rcode;
            int sel;
            rid = 8'(1 + ($urandom % 23));
            if ($urandom % 8 == 0) rid = 8'(8'h18 + ($urandom % 200));
            sel = $urandom % 6;
            case (sel)
                0: rcode = 8'h01; 1: rcode = 8'hFF; 2: rcode = 8'hFE;
                3: rcode = 8'hFD; 4: rcode = 8'hFC; default: rcode = 8'h23;
            endcase
            run_cmd(rid, $urandom, ($urandom % 2) ? 0 : int'(1 + $urandom % 8),
                    int'(1 + $urandom % 15), rcode, $urandom, 0);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule